// File: doc/BRIEF.md
# Processor Bank-Switching ROM Address Mapper

This block sits between an 8-bit processor's 16-bit address bus and a ROM of up to 512KiB. It produces the upper ROM address (ROM address bits 18 to 11) from the processor address and four bank registers. The lower half of processor space, 0000h to 7FFFh, reaches a fixed 32KiB region of ROM. The upper half is split into four windows of 16, 8, 4 and 2KiB. Each window is redirected to any bank of ROM through its own register.

Bank registers are written through an externally decoded, active-low write strobe. No data bus is used for this. The two lowest address bits pick the register, and the bank number rides on the upper address byte. While the strobe is low, the ROM address outputs float. The strobe and address are sampled on the block clock. A register is loaded on the first clock edge that sees the strobe high again. The value loaded is the address captured on the last clock edge during which the strobe was low.

Top module: `bank_rom_mapper`

## Requirements
- R1: With the strobe high and address bit 15 clear, rom_addr equals {4'b0000, addr[14:11]} in the same cycle.
- R2: With the strobe high and addr[15:12] = 1111 (F000h to FFFFh, so F800h to FFFFh alias onto F000h to F7FFh), rom_addr equals the full 8-bit register of zone 0.
- R3: With the strobe high and addr[15:12] = 1110 (E000h to EFFFh), rom_addr equals {zone 1 register (7 bits), addr[11]}.
- R4: With the strobe high and addr[15:13] = 110 (C000h to DFFFh), rom_addr equals {zone 2 register (6 bits), addr[12:11]}.
- R5: With the strobe high and addr[15:14] = 10 (8000h to BFFFh), rom_addr equals {zone 3 register (5 bits), addr[13:11]}. For example, a load of 8103h makes 8000h to BFFFh read ROM 04000h to 07FFFh.
- R6: The captured addr[1:0] selects the zone (0 to 3). The zone-z register takes addr[8+W-1:8], where W is 8 minus z. Any higher address bits are ignored.
- R7: A register changes only on the first rising clock edge at which the strobe is high after an edge at which it was low. Until that edge, outputs keep the old mapping, and processor reads never change a register.
- R8: While the strobe is low, all eight rom_addr bits are high-impedance.
- R9: A synchronous active-low reset clears all four registers to zero.
- R10: A load changes only the selected register. The other three keep their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock; strobe and address are sampled on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_n | input | 1 | Decoded active-low bank write strobe |
| addr | input | 16 | Processor address; also carries zone select and bank number during a write |
| rom_addr | output | 8 | ROM address bits 18:11, high-impedance while wr_n is low |

## Verification
The mapping from address to ROM is combinational. The bench samples it 1 ns after it drives a new address at the falling clock edge, in the same cycle. Float on a low strobe is also combinational, and the bench checks it the same way. A register load takes effect at the first rising edge with the strobe high. So the bench first reads a window just after raising the strobe and expects the old bank. It then reads again half a cycle after that edge and expects the new bank. Bench functions keep a register model and compute every expected value from the address alone.

// File: rtl/bank_rom_mapper_pkg.sv
// Package: shared sizes for the bank-switching ROM mapper.
// Assumes a 16-bit processor address and 2KiB pages (page index from bit 11).
package bank_rom_mapper_pkg;
    localparam int ADDR_W   = 16;  // processor address width
    localparam int OUT_W    = 8;   // ROM address bits driven (18:11)
    localparam int NWIN     = 4;   // number of switchable windows
    localparam int PAGE_LSB = 11;  // lowest processor address bit that reaches the output
    localparam int SEL_W    = $clog2(NWIN);
    localparam int HI_W     = ADDR_W - PAGE_LSB;  // address bits above the page offset
endpackage

// File: rtl/bmap_window_decode.sv
// Module: picks the window an upper-half address falls into.
// Window i matches when the top (NWIN - i) address bits are all ones; the
// lowest matching index wins, so the 2KiB window also claims its alias area.
// Assumes HI_W = NWIN + 1 (one bit for the half select plus the window tiers).
module bmap_window_decode
    import bank_rom_mapper_pkg::*;
#(
    parameter int N_WIN = NWIN
) (
    input  logic [N_WIN-1:0] tier_i,   // address bits 15:12
    output logic [N_WIN-1:0] sel_o     // one-hot window select, zero if bit 15 clear
);
    logic [N_WIN-1:0] hit;

    // Per-window match: all ones from bit 15 down to the window's tier.
    for (genvar i = 0; i < N_WIN; i++) begin : g_hit
        assign hit[i] = &tier_i[N_WIN-1:i];
    end

    // Priority: the smallest window that matches is selected.
    always_comb begin
        sel_o = '0;
        for (int i = N_WIN - 1; i >= 0; i--) begin
            if (hit[i]) begin
                sel_o    = '0;
                sel_o[i] = 1'b1;
            end
        end
    end
endmodule

// File: rtl/bmap_bank_file.sv
// Module: four bank registers of falling width, loaded after a strobe pulse.
// Assumes wr_n and the address are stable around the rising clock edges.
// While wr_n is low the zone select and bank number are captured every cycle;
// the first edge that sees wr_n high again writes the captured number.
module bmap_bank_file
    import bank_rom_mapper_pkg::*;
#(
    parameter int N_WIN = NWIN,
    parameter int W_OUT = OUT_W,
    parameter int W_SEL = SEL_W
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_n,
    input  logic [W_SEL-1:0]            zone_i,
    input  logic [W_OUT-1:0]            num_i,
    output logic [N_WIN-1:0][W_OUT-1:0] bank_o
);
    logic             wr_q;
    logic [W_SEL-1:0] zone_q;
    logic [W_OUT-1:0] num_q;
    logic             load;

    assign load = wr_n & ~wr_q;

    // Strobe history and capture of the write fields while the strobe is low.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_q   <= 1'b1;
            zone_q <= '0;
            num_q  <= '0;
        end else begin
            wr_q <= wr_n;
            if (!wr_n) begin
                zone_q <= zone_i;
                num_q  <= num_i;
            end
        end
    end

    for (genvar i = 0; i < N_WIN; i++) begin : g_bank
        localparam int W = W_OUT - i;

        // Register i: loads its low W bits of the bank number when selected.
        always_ff @(posedge clk) begin
            if (!rst_n)
                bank_o[i] <= '0;
            else if (load && zone_q == W_SEL'(i))
                bank_o[i] <= W_OUT'(num_q[W-1:0]);
        end

        AST_LOAD_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
            (load && zone_q == W_SEL'(i)) |=> bank_o[i] == W_OUT'($past(num_q[W-1:0]))); // R6
        AST_OTHER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            !(load && zone_q == W_SEL'(i)) |=> $stable(bank_o[i])); // R10
    end

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(bank_o)); // R7
endmodule

// File: rtl/bmap_compose.sv
// Module: builds the ROM page number from the window select and banks.
// Lower half passes address bits 14:11 through; window i concatenates its
// (W_OUT - i)-bit bank with the i address bits just above bit 10.
module bmap_compose
    import bank_rom_mapper_pkg::*;
#(
    parameter int N_WIN = NWIN,
    parameter int W_OUT = OUT_W
) (
    input  logic                        upper_i,  // address bit 15
    input  logic [N_WIN-1:0]            low_i,    // address bits 14:11
    input  logic [N_WIN-1:0]            sel_i,
    input  logic [N_WIN-1:0][W_OUT-1:0] bank_i,
    output logic [W_OUT-1:0]            page_o
);
    logic [W_OUT-1:0] lo_ext;

    assign lo_ext = W_OUT'(low_i[N_WIN-2:0]);

    // Output mux: pass-through, or the selected bank joined with offset bits.
    always_comb begin
        page_o = upper_i ? '0 : W_OUT'(low_i);
        for (int i = 0; i < N_WIN; i++) begin
            if (upper_i && sel_i[i])
                page_o = (bank_i[i] << i) | (lo_ext & W_OUT'((1 << i) - 1));
        end
    end
endmodule

// File: rtl/bank_rom_mapper.sv
// Top: bank-switching ROM address mapper.
// Assumes one clock shared with the strobe decoder; the output floats
// combinationally whenever wr_n is low.
module bank_rom_mapper
    import bank_rom_mapper_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_n,
    input  logic [ADDR_W-1:0] addr,
    output logic [OUT_W-1:0]  rom_addr
);
    logic [NWIN-1:0]            win_sel;
    logic [NWIN-1:0][OUT_W-1:0] banks;
    logic [OUT_W-1:0]           page;
    logic                       unused_mid;

    assign unused_mid = ^addr[7:SEL_W];

    bmap_window_decode #(.N_WIN(NWIN)) u_dec (
        .tier_i (addr[ADDR_W-1:ADDR_W-NWIN]),
        .sel_o  (win_sel)
    );

    bmap_bank_file #(.N_WIN(NWIN), .W_OUT(OUT_W), .W_SEL(SEL_W)) u_banks (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_n   (wr_n),
        .zone_i (addr[SEL_W-1:0]),
        .num_i  (addr[ADDR_W-1:ADDR_W-OUT_W]),
        .bank_o (banks)
    );

    bmap_compose #(.N_WIN(NWIN), .W_OUT(OUT_W)) u_mux (
        .upper_i (addr[ADDR_W-1]),
        .low_i   (addr[ADDR_W-2:PAGE_LSB]),
        .sel_i   (win_sel),
        .bank_i  (banks),
        .page_o  (page)
    );

    // Output driver: float while a bank write is in progress.
    assign rom_addr = wr_n ? page : 'z;

    AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_n && !addr[ADDR_W-1]) |-> rom_addr == OUT_W'(addr[ADDR_W-2:PAGE_LSB])); // R1
endmodule

// File: tb/sim_bank_rom_mapper.sv
`timescale 1ns/1ps
module sim_bank_rom_mapper;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_n = 1'b1;
    logic [15:0] addr = 16'h0000;
    wire  [7:0]  rom_addr;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    logic [7:0] mb0;
    logic [6:0] mb1;
    logic [5:0] mb2;
    logic [4:0] mb3;

    always #2 clk = ~clk;

    bank_rom_mapper u0 (.clk(clk), .rst_n(rst_n), .wr_n(wr_n), .addr(addr), .rom_addr(rom_addr));

    function automatic logic [7:0] exp_map(input logic [15:0] a);
        if (!a[15])                  return {4'b0000, a[14:11]};
        else if (a[15:12] == 4'hF)   return mb0;
        else if (a[15:12] == 4'hE)   return {mb1, a[11]};
        else if (a[15:13] == 3'b110) return {mb2, a[12:11]};
        else                         return {mb3, a[13:11]};
    endfunction

    function automatic string req_of(input logic [15:0] a);
        if (!a[15])                  return "R1";
        else if (a[15:12] == 4'hF)   return "R2";
        else if (a[15:12] == 4'hE)   return "R3";
        else if (a[15:13] == 3'b110) return "R4";
        else                         return "R5";
    endfunction

    task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic read_at(input logic [15:0] a, input string tag);
        @(negedge clk);
        addr = a;
        #1;
        check({tag, "/", req_of(a)}, rom_addr, exp_map(a));
    endtask

    // Bank write: strobe low for one edge, raise it, check the old mapping
    // before the load edge and the float while low.
    task automatic write_bank(input logic [15:0] a, input logic [15:0] probe);
        @(negedge clk);
        wr_n = 1'b0;
        addr = a;
        #1;
        check("R8 float", rom_addr, 8'hzz);
        @(negedge clk);
        wr_n = 1'b1;
        addr = probe;
        #1;
        check("R7 before load", rom_addr, exp_map(probe));
        case (a[1:0])
            2'd0: mb0 = a[15:8];
            2'd1: mb1 = a[14:8];
            2'd2: mb2 = a[13:8];
            default: mb3 = a[12:8];
        endcase
    endtask

    task automatic sweep(input string tag);
        read_at(16'h8000, tag); read_at(16'hBFFF, tag);
        read_at(16'hC000, tag); read_at(16'hDFFF, tag);
        read_at(16'hE000, tag); read_at(16'hEFFF, tag);
        read_at(16'hF000, tag); read_at(16'hF800, tag);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        wr_n  = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        mb0 = '0; mb1 = '0; mb2 = '0; mb3 = '0;
    endtask

    task automatic finish_run();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        #400000;
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: got hang expected completion");
            finish_run();
        end
    end

    initial begin
        logic [15:0] r;
        void'($urandom(32'd20240611));
        do_reset();
        // R9: reset state maps every window to bank 0
        sweep("R9 reset");
        read_at(16'h0000, "pass"); read_at(16'h7FFF, "pass");
        // R5/R6: example loads
        write_bank(16'h8003, 16'hA000);
        read_at(16'h8000, "R6 8003");
        write_bank(16'h8103, 16'hA000);
        read_at(16'hA000, "R6 8103");
        check("R5 example 8103", rom_addr, 8'h0C);
        // R6: excess bits ignored, each zone width
        write_bank(16'hFF03, 16'h8800); sweep("R6 zone3 wide");
        write_bank(16'hFF02, 16'hC800); sweep("R6 zone2 wide");
        write_bank(16'hFF01, 16'hE800); sweep("R6 zone1 wide");
        write_bank(16'hA500, 16'hF000); sweep("R10 zone0");
        // R10: one zone changes, others keep
        write_bank(16'h1202, 16'hD000); sweep("R10 zone2");
        // R7: reads never load
        for (int k = 0; k < 20; k++) read_at(16'(($urandom() | 32'h8000)), "R7 reads");
        // random mix
        for (int k = 0; k < 300; k++) begin
            r = 16'($urandom());
            if (($urandom() % 4) == 0) write_bank(r, 16'(($urandom() | 32'h8000)));
            else read_at(r, "rand");
        end
        // R9: reset clears loaded banks
        do_reset();
        sweep("R9 second reset");
        done = 1'b1;
        finish_run();
    end
endmodule